// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions on the two-wire PHY management bus: a clock line (MDC) that it drives, and a shared bidirectional data line (MDIO). Software places a complete 32-bit frame word in the frame register. Writing that register starts a transaction. The block sends 32 ones as a preamble and then the frame word, most significant bit first. When the frame is a read, the block lets go of the data line at the second turnaround bit. It then shifts the PHY's 16 reply bits into the low half of the same frame register.

A sticky done flag in the event register marks the end of every transaction, and software clears it by writing one. A busy bit next to it shows that a transaction is in flight. The speed register sets the MDC half-period in system clocks. Software normally programs it as the bus clock in MHz divided by five. Completion is only ever polled: the block has no interrupt output.

The register port is a plain single-cycle write strobe with a combinational read mux. It is control traffic with no flow control, so it has no valid/ready handshake. The serial side has no back-pressure either: the PHY must keep up with MDC.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset the frame register (address 0) reads 0, the event register (address 1) reads 0 and the speed register (address 2) reads 0.
- R2: A transaction puts exactly 64 MDC rising edges on the bus. The MDIO values at those edges are 32 ones followed by frame bits 31 down to 0. The frame fields are: start code in bits 31:30, opcode in bits 29:28, PHY address in bits 27:23, register number in bits 22:18, turnaround in bits 17:16 and data in bits 15:0.
- R3: The speed register holds its field in bits 6:1. Each MDC high and low phase lasts that many system clocks. While the field is zero, MDC stays low and the transaction makes no progress; it resumes once the field is made nonzero.
- R4: While MDC is high, MDIO does not change. A new bit appears only at the system-clock edge on which MDC falls.
- R5: Only opcode 10 (read) releases MDIO: the output enable is low from the second turnaround bit (serial bit 47) through the last bit. The PHY's 16 bits, sampled on MDC rising edges most significant bit first, replace frame bits 15:0 at completion, and bits 31:16 keep their value. Any other opcode, including write opcode 01, drives MDIO for all 64 bits.
- R6: Event bit 0 (done) sets when a transaction completes and stays set. Writing 1 to event bit 0 clears it, and so does writing all ones to the event register. Writing 0 to bit 0 leaves it unchanged.
- R7: Event bit 1 (busy) reads 1 from the cycle after an accepted frame-register write until the cycle in which done sets, and reads 0 otherwise.
- R8: A frame-register write while busy is ignored. The frame register keeps its value, the transaction in progress is not restarted, and no second transaction follows.
- R9: When idle, MDC is low and MDIO is released (output enable low).
- R10: A read from an address where no PHY drives the pulled-up line returns 0xFFFF in frame bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0 frame, 1 event, 2 speed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable (1 drives the line) |
| mdio_i | input | 1 | Management data line as seen at the pin |

## Verification
The bench models the pulled-up line and a PHY that drives reply bits only while the block has released it. Against that model it records the line and the enable at every MDC rising edge and compares them bit by bit.

The corner cases it targets are these:
- The release point at the second turnaround bit. A design off by one would fight the PHY or float a bit it should drive.
- A command write that arrives mid-transfer. A design without the busy guard would overwrite the frame or restart, and so produce more than 64 clocks.
- A read with nobody answering, which must come back as all ones.
- A zero speed field. It must stall the transfer rather than wrap the divider.

It also confirms the following. Done survives a write of zero. The upper half of the frame survives a read. MDIO never moves during an MDC high phase, which is the error a design would make if it shifted on the rising edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;
  localparam int OP_HI   = 29;
  localparam int OP_LO   = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    RA_FRAME = 2'd0,
    RA_EVENT = 2'd1,
    RA_SPEED = 2'd2,
    RA_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SPD_W-1:0] half,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [SPD_W-1:0] cnt;
  logic             tick;

  assign tick     = run && (half != '0) && (cnt >= half - 1'b1);
  assign rise_stb = tick && !mdc;
  assign fall_stb = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (half != '0) begin
      if (tick) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: clock parks low when no transfer runs
  a_r9_mdc_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  // R3: zero speed field freezes the clock
  a_r3_zero_speed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run && half == '0) |=> $stable(mdc));
endmodule

// File: rtl/mdio_serializer.sv
module mdio_serializer #(
  parameter int PRE_LEN = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [mdio_pkg::FRAME_W-1:0] cmd,
  input  logic                        rise_stb,
  input  logic                        fall_stb,
  input  logic                        mdio_i,
  output logic                        active,
  output logic                        finish,
  output logic                        is_read,
  output logic [mdio_pkg::DATA_W-1:0]  rd_data,
  output logic                        mdio_o,
  output logic                        mdio_oe
);
  import mdio_pkg::*;

  localparam int TOT     = PRE_LEN + FRAME_W;
  localparam int IW      = $clog2(TOT);
  localparam int CAP_IDX = TOT - DATA_W;
  localparam int REL_IDX = CAP_IDX - 1;

  logic [TOT-1:0]    sr;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] cap;
  logic              last_bit;

  assign last_bit = (idx == IW'(TOT - 1));
  assign finish   = active && fall_stb && last_bit;
  assign rd_data  = cap;
  assign mdio_o   = active ? sr[TOT-1] : 1'b1;
  assign mdio_oe  = active && !(is_read && idx >= IW'(REL_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr      <= '1;
      idx     <= '0;
      cap     <= '0;
      active  <= 1'b0;
      is_read <= 1'b0;
    end else if (start) begin
      sr      <= {{PRE_LEN{1'b1}}, cmd};
      idx     <= '0;
      cap     <= '0;
      active  <= 1'b1;
      is_read <= (cmd[OP_HI:OP_LO] == OP_READ);
    end else if (active) begin
      if (rise_stb && is_read && idx >= IW'(CAP_IDX))
        cap <= {cap[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        if (last_bit) begin
          active <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          sr  <= {sr[TOT-2:0], 1'b1};
        end
      end
    end
  end

  // R4: data only moves on a falling clock strobe
  a_r4_hold_until_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fall_stb && !start) |=> $stable(mdio_o));
  // R2: a finish only ever follows an active transfer
  a_r2_finish_ends_active: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !active);
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int SPD_W   = 6,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_pkg::*;

  logic [FRAME_W-1:0] frame_q;
  logic [SPD_W-1:0]   spd_q;
  logic               done_q;
  logic               busy, finish, is_read, start;
  logic               rise_stb, fall_stb;
  logic [DATA_W-1:0]  rd_data;
  logic               wr_frame, wr_event, wr_speed;

  assign wr_frame = reg_wr && (reg_addr == RA_FRAME);
  assign wr_event = reg_wr && (reg_addr == RA_EVENT);
  assign wr_speed = reg_wr && (reg_addr == RA_SPEED);
  assign start    = wr_frame && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      spd_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (start)
        frame_q <= reg_wdata;
      else if (finish && is_read)
        frame_q[DATA_W-1:0] <= rd_data;
      if (wr_speed)
        spd_q <= reg_wdata[SPD_W:1];
      if (finish)
        done_q <= 1'b1;
      else if (wr_event && reg_wdata[0])
        done_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_FRAME: reg_rdata = frame_q;
      RA_EVENT: reg_rdata = {30'd0, busy, done_q};
      RA_SPEED: reg_rdata = {{(31 - SPD_W){1'b0}}, spd_q, 1'b0};
      default:  reg_rdata = '0;
    endcase
  end

  mdio_clk_gen #(.SPD_W(SPD_W)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .half     (spd_q),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_serializer #(.PRE_LEN(PRE_LEN)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd      (reg_wdata),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .active   (busy),
    .finish   (finish),
    .is_read  (is_read),
    .rd_data  (rd_data),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  // R6: busy dropping always leaves the done flag set
  a_r6_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);
  // R8: frame register untouched by a write during a transfer
  a_r8_ignore_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_frame && !finish) |=> (frame_q == $past(frame_q)));
  // R5: line released only for a read opcode
  a_r5_release_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |-> (frame_q[OP_HI:OP_LO] == OP_READ));
  // R9: idle means released line and low clock
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));
endmodule

// File: tb/sim_mdio_frame_master.sv
module sim_mdio_frame_master;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_line;

  logic        phy_en = 1'b0;
  logic [15:0] phy_resp = '0;
  logic        mon_clr = 1'b0;
  int          rise_n;
  logic [63:0] line_bits, oe_bits;
  logic        phy_drive, phy_bit;

  int checks = 0;
  int fails  = 0;
  int viol   = 0;
  int hl_cnt = 0;
  int last_high = 0;
  logic prev_o = 1'b1;

  always #(CLK_NS/2) clk = ~clk;

  assign phy_drive = phy_en && (rise_n >= 48) && (rise_n <= 63);
  assign phy_bit   = phy_drive ? phy_resp[4'(63 - rise_n)] : 1'b1;
  assign mdio_line = mdio_oe ? mdio_o : (phy_drive ? phy_bit : 1'b1);

  mdio_frame_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  always @(posedge mdc or posedge mon_clr) begin
    if (mon_clr) begin
      rise_n <= 0; line_bits <= '0; oe_bits <= '0;
    end else begin
      rise_n    <= rise_n + 1;
      line_bits <= {line_bits[62:0], mdio_line};
      oe_bits   <= {oe_bits[62:0], mdio_oe};
    end
  end

  always @(negedge clk) begin
    if (rst_n && mdc && (mdio_o !== prev_o)) viol = viol + 1;
    prev_o = mdio_o;
    if (mdc) hl_cnt = hl_cnt + 1;
    else if (hl_cnt != 0) begin last_high = hl_cnt; hl_cnt = 0; end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic clr_mon();
    mon_clr = 1'b1; #1; mon_clr = 1'b0;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd1, v);
      if (v[0]) return;
    end
    check(req, 64'd0, 64'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); check("R1 frame reset", 64'(v), 64'd0);
    rd(2'd1, v); check("R1 event reset", 64'(v), 64'd0);
    rd(2'd2, v); check("R1 speed reset", 64'(v), 64'd0);
    check("R9 idle mdc low", 64'(mdc), 64'd0);
    check("R9 idle released", 64'(mdio_oe), 64'd0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    logic [31:0] cmd = 32'h5002_0000 | (32'd3 << 23) | (32'd5 << 18) | 32'h0000_A5C3;
    wr(2'd2, 32'd4);
    rd(2'd2, v); check("R3 speed readback", 64'(v), 64'd4);
    viol = 0; clr_mon();
    wr(2'd0, cmd);
    rd(2'd1, v); check("R7 busy after write", 64'(v), 64'd2);
    wait_done("R6 write done");
    check("R2 write bits", line_bits, {32'hFFFF_FFFF, cmd});
    check("R2 rise count", 64'(rise_n), 64'd64);
    check("R5 write drives all", oe_bits, '1);
    check("R4 stable while high", 64'(viol), 64'd0);
    check("R3 half period 2", 64'(last_high), 64'd2);
    rd(2'd1, v); check("R7 busy clear with done", 64'(v), 64'd1);
    check("R9 released after", 64'(mdio_oe), 64'd0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(2'd1, 32'd0);
    rd(2'd1, v); check("R6 write zero keeps done", 64'(v), 64'd1);
    wr(2'd1, 32'd1);
    rd(2'd1, v); check("R6 write one clears", 64'(v), 64'd0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    logic [31:0] cmd = 32'h6002_0000 | (32'd1 << 23) | (32'd2 << 18);
    wr(2'd2, 32'd6);
    phy_resp = 16'h1234; phy_en = 1'b1;
    viol = 0; clr_mon();
    wr(2'd0, cmd);
    wait_done("R6 read done");
    phy_en = 1'b0;
    rd(2'd0, v); check("R5 read data", 64'(v), 64'({cmd[31:16], 16'h1234}));
    check("R5 release at bit 47", oe_bits, 64'hFFFF_FFFF_FFFE_0000);
    check("R5 line data", 64'(line_bits[15:0]), 64'h1234);
    check("R3 half period 3", 64'(last_high), 64'd3);
    check("R4 stable on read", 64'(viol), 64'd0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    logic [31:0] a = 32'h6002_0000 | (32'd7 << 23) | (32'd9 << 18);
    logic [31:0] b = 32'h5002_0000 | (32'd2 << 23) | 32'h0000_0F0F;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R6 all ones clears", 64'(v), 64'd0);
    wr(2'd2, 32'd2);
    phy_resp = 16'hBEEF; phy_en = 1'b1;
    clr_mon();
    wr(2'd0, a);
    repeat (40) @(negedge clk);
    wr(2'd0, b);
    rd(2'd0, v); check("R8 frame kept", 64'(v), 64'(a));
    wait_done("R8 first done");
    phy_en = 1'b0;
    rd(2'd0, v); check("R8 result of first", 64'(v), 64'({a[31:16], 16'hBEEF}));
    check("R8 no restart bits", 64'(line_bits[63:18]), 64'({32'hFFFF_FFFF, a[31:18]}));
    repeat (300) @(negedge clk);
    check("R8 no second transfer", 64'(rise_n), 64'd64);
    rd(2'd1, v); check("R8 idle after", 64'(v), 64'd1);
    wr(2'd1, 32'd1);
  endtask

  task automatic t_nophy();
    logic [31:0] v;
    logic [31:0] cmd = 32'h6002_0000 | (32'd31 << 23) | (32'd1 << 18);
    wr(2'd0, cmd);
    wait_done("R10 done");
    rd(2'd0, v); check("R10 no phy all ones", 64'(v), 64'({cmd[31:16], 16'hFFFF}));
    wr(2'd1, 32'd1);
  endtask

  task automatic t_speed0();
    logic [31:0] v;
    wr(2'd2, 32'd0);
    clr_mon();
    wr(2'd0, 32'h5002_1234);
    repeat (60) @(negedge clk);
    check("R3 zero speed mdc low", 64'(mdc), 64'd0);
    check("R3 zero speed no edges", 64'(rise_n), 64'd0);
    rd(2'd1, v); check("R7 busy while stalled", 64'(v), 64'd2);
    wr(2'd2, 32'd4);
    wait_done("R3 resume");
    check("R3 resumed 64 edges", 64'(rise_n), 64'd64);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_w1c();
        t_read();
        t_busy_ignore();
        t_nophy();
        t_speed0();
      end
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule